// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps a small set of sticky flags that tell software what kind of event caused the most recent reset. There are four event inputs: power-on, external pin, brown-out and watchdog. Each arrives as a one-cycle pulse from reset logic elsewhere in the chip. Each pulse sets its own flag on the next clock edge. A power-on event also wipes the other three flags. Flags stay set across every other kind of reset.

Software reads the register over a simple synchronous register port, with a read strobe, a write strobe and 8-bit data. It clears any flag by writing a zero to that bit. Writing a one leaves the bit unchanged. The usual pattern is to read and clear the register early after boot, so that a later reset leaves only its own flag behind.

The flag storage has no reset of its own. The power-on event is the only thing that initialises it. The system reset input exists only so that checking logic can tell when the flags are meaningful; it has no effect on the stored values.

Top module: `reset_origin_log`

## Requirements
- R1: Data bits 7 to 4 always read as zero. Writes to those bits have no effect on any flag.
- R2: An event pulse sets its flag at the next clock edge. The bit positions are: watchdog at bit 3, brown-out at bit 2, external pin at bit 1, power-on at bit 0.
- R3: A power-on pulse clears bits 3, 2 and 1 and sets bit 0 at the next edge.
- R4: If another event pulses in the same cycle as a power-on pulse, that event's flag is still set.
- R5: A write with a 0 in bit n (n from 0 to 3) clears flag n at the next edge. A write with a 1 in bit n leaves flag n unchanged.
- R6: Bit 0 is never cleared by any event. Only a software write of 0 clears it.
- R7: External, brown-out and watchdog events leave all flags other than their own unchanged.
- R8: When an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: Asserting or releasing the system reset input (sysRstN) does not change any flag.
- R10: While busRd is high, busRdata equals the four flags in bits 3 to 0, combinationally and in the same cycle. While busRd is low, busRdata is zero.
- R11: With no event and no write, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | Active-low system reset; does not affect the flags |
| evtPowerOn | input | 1 | Power-on event pulse |
| evtExtPin | input | 1 | External pin reset event pulse |
| evtBrownOut | input | 1 | Brown-out reset event pulse |
| evtWatchdog | input | 1 | Watchdog reset event pulse |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data; a 0 clears the matching flag |
| busRdata | output | 8 | Read data, zero when busRd is low |

## Verification
The hardest cases to reach are collisions inside one cycle. These are a power-on pulse together with other events and a software write, and a software clear landing on a bit in the same cycle as its event. The stimulus drives these combinations on purpose: power-on with watchdog, power-on with a clearing write, and each event paired with a zero write to its own bit. It also toggles sysRstN while flags are set, to show that the stored values survive the system reset. A behavioural model in the bench predicts the flags on every clock and compares them with a read on every cycle.

// File: rtl/reset_origin_pkg.sv
package reset_origin_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int POR_IDX   = 0;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setMask;
    logic [NUM_FLAGS-1:0] clrMask;
    logic                 wipe;
  } flagCmd_t;
endpackage

// File: rtl/reset_origin_ctrl.sv
module reset_origin_ctrl
  import reset_origin_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] evtVec,
  input  logic                 busWr,
  input  logic [NUM_FLAGS-1:0] wrBits,
  output flagCmd_t             cmd
);
  always_comb begin
    cmd.setMask = evtVec;
    cmd.clrMask = busWr ? ~wrBits : '0;
    cmd.wipe    = evtVec[POR_IDX];
  end
endmodule

// File: rtl/reset_origin_dp.sv
module reset_origin_dp
  import reset_origin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  flagCmd_t          cmd,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata
);
  logic [NUM_FLAGS-1:0] flagQ;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic wipeHit;
    if (i == POR_IDX) begin : g_por
      assign wipeHit = 1'b0;
    end else begin : g_other
      assign wipeHit = cmd.wipe;
    end

    always_ff @(posedge clk) begin
      if (cmd.setMask[i])               flagQ[i] <= 1'b1;
      else if (wipeHit || cmd.clrMask[i]) flagQ[i] <= 1'b0;
    end

    // R2 / R8: an event sets the bit even against a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!sysRstN)
      cmd.setMask[i] |=> flagQ[i]);
    // R5: a software clear without an event clears the bit
    p_clear_r5: assert property (@(posedge clk) disable iff (!sysRstN)
      cmd.clrMask[i] && !cmd.setMask[i] |=> !flagQ[i]);
    // R11: no command keeps the bit
    p_hold_r11: assert property (@(posedge clk) disable iff (!sysRstN)
      !cmd.setMask[i] && !cmd.clrMask[i] && !wipeHit |=> $stable(flagQ[i]));
    if (i != POR_IDX) begin : g_wipe_chk
      // R3: power-on wipes the non power-on flags
      p_wipe_r3: assert property (@(posedge clk) disable iff (!sysRstN)
        cmd.wipe && !cmd.setMask[i] |=> !flagQ[i]);
    end
  end

  assign busRdata = busRd ? {{(DATA_W-NUM_FLAGS){1'b0}}, flagQ} : '0;
endmodule

// File: rtl/reset_origin_log.sv
module reset_origin_log
  import reset_origin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              evtPowerOn,
  input  logic              evtExtPin,
  input  logic              evtBrownOut,
  input  logic              evtWatchdog,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);
  localparam int HI = DATA_W - 1;

  flagCmd_t             cmd;
  logic [NUM_FLAGS-1:0] evtVec;

  assign evtVec = {evtWatchdog, evtBrownOut, evtExtPin, evtPowerOn};

  reset_origin_ctrl u_ctrl (
    .evtVec (evtVec),
    .busWr  (busWr),
    .wrBits (busWdata[NUM_FLAGS-1:0]),
    .cmd    (cmd)
  );

  reset_origin_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .sysRstN  (sysRstN),
    .cmd      (cmd),
    .busRd    (busRd),
    .busRdata (busRdata)
  );

  // R10: idle read port drives zero
  p_read_idle_r10: assert property (@(posedge clk) disable iff (!sysRstN)
    !busRd |-> (busRdata == '0));
  // R1: upper bits stay zero after a write touching them
  p_reserved_ignored_r1: assert property (@(posedge clk) disable iff (!sysRstN)
    busWr && (|busWdata[HI:NUM_FLAGS]) |=> (busRdata[HI:NUM_FLAGS] == '0));
  // R6: power-on flag is set after a power-on pulse
  p_por_sets_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    evtPowerOn && busRd |=> (busRdata[POR_IDX] || !busRd));
endmodule

// File: tb/sim_reset_origin_log.sv
module sim_reset_origin_log;
  logic clk = 1'b0;
  logic sysRstN, evtPowerOn, evtExtPin, evtBrownOut, evtWatchdog;
  logic busRd, busWr;
  logic [7:0] busWdata, busRdata;
  logic [3:0] model;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reset_origin_log u0 (.*);

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (busRdata !== exp) begin
      fails++;
      $display("FAIL %s: busRdata=%h expected=%h", tag, busRdata, exp);
    end
  endtask

  // drive one cycle: check read data before the edge, then update the model
  task automatic step(input string tag, input logic por, ext, bo, wd,
                      input logic wr, input logic [7:0] wdat, input logic rd);
    @(negedge clk);
    evtPowerOn = por; evtExtPin = ext; evtBrownOut = bo; evtWatchdog = wd;
    busWr = wr; busWdata = wdat; busRd = rd;
    #1;
    check(tag, rd ? {4'b0, model} : 8'h00);
    @(posedge clk);
    if (wr) model = model & wdat[3:0];
    if (por) model[3:1] = 3'b000;
    model = model | {wd, bo, ext, por};
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    sysRstN = 0; evtPowerOn = 0; evtExtPin = 0; evtBrownOut = 0; evtWatchdog = 0;
    busRd = 0; busWr = 0; busWdata = 0;
    model = 4'b0000;
    // power-on initialises storage; model starts from its result
    @(negedge clk); evtPowerOn = 1;
    @(posedge clk); model = 4'b0001;
    @(negedge clk); evtPowerOn = 0; sysRstN = 1;
    step("R3 reset state", 0,0,0,0, 0,8'h00, 1);
    step("R10 idle read zero", 0,0,0,0, 0,8'h00, 0);
    step("R2 watchdog", 0,0,0,1, 0,8'h00, 1);
    step("R2 brownout", 0,0,1,0, 0,8'h00, 1);
    step("R7 ext keeps others", 0,1,0,0, 0,8'h00, 1);
    step("R11 hold", 0,0,0,0, 0,8'h00, 1);
    step("R5 write ones no change", 0,0,0,0, 1,8'hFF, 1);
    step("R5 clear bit 2", 0,0,0,0, 1,8'hFB, 1);
    step("R1 reserved write", 0,0,0,0, 1,8'hF0, 1);
    step("R1 reserved readback", 0,0,0,0, 0,8'h00, 1);
    step("R6 events keep por clear", 0,1,1,1, 0,8'h00, 1);
    step("R6 por stays clear", 0,0,0,0, 0,8'h00, 1);
    step("R3 power-on wipes", 1,0,0,0, 0,8'h00, 1);
    step("R6 only write clears bit0", 0,1,0,0, 0,8'h00, 1);
    step("R5 clear bit0", 0,0,0,0, 1,8'hFE, 1);
    step("R8 set beats clear", 0,0,1,0, 1,8'h00, 1);
    step("R8 readback", 0,0,0,1, 1,8'hF7, 1);
    step("R8 result", 0,0,0,0, 0,8'h00, 1);
    step("R4 por with watchdog", 1,0,0,1, 0,8'h00, 1);
    step("R4 result", 0,0,0,0, 0,8'h00, 1);
    step("R4 por with clear write", 1,1,0,0, 1,8'h00, 1);
    step("R4 result2", 0,0,0,0, 0,8'h00, 1);
    step("R7 watchdog sets", 0,0,0,1, 0,8'h00, 1);
    // system reset toggle must not touch flags
    @(negedge clk); sysRstN = 0;
    repeat (3) @(negedge clk);
    busRd = 1; #1;
    check("R9 during sysRst", {4'b0, model});
    sysRstN = 1;
    step("R9 after sysRst", 0,0,0,0, 0,8'h00, 1);
    for (int k = 0; k < 16; k++) begin
      step("R5 sweep write", 0,0,0,0, 1,{4'hA, k[3:0]}, 1);
      step("R2 sweep event", 0, k[0], k[1], k[2], 0,8'h00, 1);
    end
    step("R10 final", 0,0,0,0, 0,8'h00, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule